// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Controller

This block moves a programmed number of 32-bit words between one peripheral and main memory without the data ever entering the controller. Software writes a starting byte address, a word count and a direction, then arms the channel. Each time the peripheral signals that one word is ready, the controller asks the processor for the system bus. When the processor grants the bus, the controller spends exactly one bus slot on a fly-by transfer: it drives the memory address, fires a memory strobe and the opposite I/O strobe together, and acknowledges the peripheral. It then gives the bus back.

Because the bus is borrowed for a single word and returned at once, the processor loses only one slot per word. A stolen-slot counter lets the system measure that cost against the programmed length. When the last word has moved, the channel reports completion and pulses an interrupt. It then stays deaf to the peripheral until software arms it again.

Top module: `csdma_ctrl`

## Requirements
- R1: After reset, hold, dev_ack, all four strobes, done and irq are low, addr_out is zero and steal_cnt is zero.
- R2: A register write with cfg_sel=0 loads the start byte address and cfg_sel=1 loads the word count. cfg_sel=2 writes control: bit 0 sets the direction (0 = memory to device, 1 = device to memory), and bit 1 set to 1 arms the channel, clears done and clears steal_cnt. While the channel is armed and not yet done, every register write is ignored.
- R3: With the channel armed, hlda low and dev_req high, hold rises on the next clock edge. dev_ack and the strobes stay low until hlda has been seen high.
- R4: The transfer slot begins on the clock edge after hlda is sampled high and lasts exactly one clock. During that slot dev_ack is high.
- R5: In the transfer slot, direction 0 asserts mem_rd with io_wr, and direction 1 asserts mem_wr with io_rd. No other combination of the four strobes ever appears.
- R6: hold drops on the clock edge that ends the transfer slot. A new hold is raised only after hlda has been sampled low.
- R7: The address driven in the n-th transfer after arming is the start address plus 4·n, modulo 2^32.
- R8: When the word count reaches zero, done goes high and irq pulses for exactly one clock. After that, dev_req causes no hold until the channel is re-armed.
- R9: steal_cnt increments by one per transfer slot, so after a job it equals the programmed word count.
- R10: Arming with a word count of zero sets done and pulses irq once, with no bus request.
- R11: Outside the transfer slot, addr_out is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 control) |
| cfg_wdata | input | 32 | Register write data |
| dev_req | input | 1 | Peripheral ready for one word |
| dev_ack | output | 1 | Peripheral acknowledge during the transfer slot |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| addr_out | output | 32 | Memory byte address during the transfer slot |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| done | output | 1 | Job complete |
| irq | output | 1 | Completion interrupt pulse |
| steal_cnt | output | 16 | Bus slots taken since the last arm |

## Verification
The bench uses a processor model that is slow to release the bus, together with a peripheral that keeps its request high. A controller that re-raised hold before seeing the grant fall would then show a hold rising while hlda is still high. A scoreboard of expected addresses and strobe pairs catches several faults: an address stride or wrap error, swapped strobe pairs, a slot longer than one clock, and an address-register write that leaked in during a live job. After completion the bench keeps the request high and watches for any hold. It also arms with a zero count, where a controller that waited for a peripheral word would never flag done.

// File: rtl/csdma_pkg.sv
package csdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_REL  = 2'd3
   } csdma_state_e;

   typedef enum logic {
      DIR_MEM2DEV = 1'b0,
      DIR_DEV2MEM = 1'b1
   } csdma_dir_e;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;

   localparam int CTRL_DIR_BIT = 0;
   localparam int CTRL_ARM_BIT = 1;

endpackage

// File: rtl/csdma_chan_regs.sv
module csdma_chan_regs
   import csdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 16,
   parameter int REG_W = 32,
   parameter int STEP  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             word_done,
   output logic [AW-1:0]    cur_addr,
   output logic             dir,
   output logic             active,
   output logic             done,
   output logic             arm_pulse,
   output logic             done_set
);

   localparam logic [AW-1:0] ADDR_INC = AW'(STEP);
   localparam logic [CW-1:0] CNT_ONE  = CW'(1);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic          dir_q;
   logic          active_q;
   logic          done_q;
   logic          wr_open;
   logic          last_word;
   logic          cnt_zero;
   logic          unused_wdata;

   assign unused_wdata = ^cfg_wdata;
   assign wr_open      = cfg_we && !active_q;
   assign arm_pulse    = wr_open && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_ARM_BIT];
   assign cnt_zero     = (cnt_q == '0);
   assign last_word    = word_done && active_q && (cnt_q == CNT_ONE);
   assign done_set     = last_word || (arm_pulse && cnt_zero);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         cnt_q    <= '0;
         dir_q    <= 1'b0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (wr_open) begin
         unique case (cfg_sel)
            SEL_ADDR:  addr_q <= cfg_wdata[AW-1:0];
            SEL_COUNT: cnt_q  <= cfg_wdata[CW-1:0];
            SEL_CTRL: begin
               dir_q <= cfg_wdata[CTRL_DIR_BIT];
               if (cfg_wdata[CTRL_ARM_BIT]) begin
                  active_q <= !cnt_zero;
                  done_q   <= cnt_zero;
               end
            end
            default: ;
         endcase
      end else if (word_done && active_q) begin
         addr_q <= addr_q + ADDR_INC;
         cnt_q  <= cnt_q - CNT_ONE;
         if (cnt_q == CNT_ONE) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
         end
      end
   end

   assign cur_addr = addr_q;
   assign dir      = dir_q;
   assign active   = active_q;
   assign done     = done_q;

endmodule

// File: rtl/csdma_seq.sv
module csdma_seq
   import csdma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic dev_req,
   input  logic hlda,
   output logic hold,
   output logic xfer
);

   csdma_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (active && dev_req && !hlda) st_d = ST_REQ;
         ST_REQ:  if (hlda) st_d = ST_XFER;
         ST_XFER: st_d = ST_REL;
         ST_REL:  if (!hlda) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign hold = (st_q == ST_REQ) || (st_q == ST_XFER);
   assign xfer = (st_q == ST_XFER);

endmodule

// File: rtl/csdma_bus_drv.sv
module csdma_bus_drv
   import csdma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          xfer,
   input  logic          dir,
   input  logic [AW-1:0] cur_addr,
   output logic [AW-1:0] addr_out,
   output logic          dev_ack,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          io_rd,
   output logic          io_wr
);

   logic to_mem;

   assign to_mem   = (dir == DIR_DEV2MEM);
   assign addr_out = xfer ? cur_addr : '0;
   assign dev_ack  = xfer;
   assign mem_rd   = xfer && !to_mem;
   assign io_wr    = xfer && !to_mem;
   assign mem_wr   = xfer && to_mem;
   assign io_rd    = xfer && to_mem;

endmodule

// File: rtl/csdma_steal_cnt.sv
module csdma_steal_cnt #(
   parameter int SW  = 16,
   parameter bit SAT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          bump,
   output logic [SW-1:0] count
);

   localparam logic [SW-1:0] ONE = SW'(1);

   logic [SW-1:0] cnt_q, cnt_inc;

   generate
      if (SAT) begin : g_sat
         assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + ONE;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (bump)  cnt_q <= cnt_inc;
   end

   assign count = cnt_q;

endmodule

// File: rtl/csdma_ctrl.sv
module csdma_ctrl
   import csdma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CW        = 16,
   parameter int SW        = 16,
   parameter int REG_W     = 32,
   parameter int DATA_W    = 32,
   parameter bit IRQ_LEVEL = 1'b0,
   parameter bit STEAL_SAT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             dev_req,
   output logic             dev_ack,
   output logic             hold,
   input  logic             hlda,
   output logic [AW-1:0]    addr_out,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             io_rd,
   output logic             io_wr,
   output logic             done,
   output logic             irq,
   output logic [SW-1:0]    steal_cnt
);

   localparam int STEP = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("csdma_ctrl: DATA_W must be a whole number of bytes");
      end
      if (AW > REG_W || AW < 2) begin : g_bad_aw
         $error("csdma_ctrl: AW must be between 2 and REG_W");
      end
      if (CW > REG_W || CW < 1) begin : g_bad_cw
         $error("csdma_ctrl: CW must be between 1 and REG_W");
      end
      if (SW < 1) begin : g_bad_sw
         $error("csdma_ctrl: SW must be at least 1");
      end
   endgenerate

   logic [AW-1:0] cur_addr;
   logic          dir;
   logic          active;
   logic          arm_pulse;
   logic          done_set;
   logic          xfer;

   csdma_chan_regs #(
      .AW    (AW),
      .CW    (CW),
      .REG_W (REG_W),
      .STEP  (STEP)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .word_done (xfer),
      .cur_addr  (cur_addr),
      .dir       (dir),
      .active    (active),
      .done      (done),
      .arm_pulse (arm_pulse),
      .done_set  (done_set)
   );

   csdma_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .dev_req (dev_req),
      .hlda    (hlda),
      .hold    (hold),
      .xfer    (xfer)
   );

   csdma_bus_drv #(
      .AW (AW)
   ) u_bus (
      .xfer     (xfer),
      .dir      (dir),
      .cur_addr (cur_addr),
      .addr_out (addr_out),
      .dev_ack  (dev_ack),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .io_rd    (io_rd),
      .io_wr    (io_wr)
   );

   csdma_steal_cnt #(
      .SW  (SW),
      .SAT (STEAL_SAT)
   ) u_steal (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (arm_pulse),
      .bump  (xfer),
      .count (steal_cnt)
   );

   generate
      if (IRQ_LEVEL) begin : g_irq_level
         logic unused_done_set;
         assign unused_done_set = done_set;
         assign irq = done;
      end else begin : g_irq_pulse
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done_set;
         end
         assign irq = irq_q;
      end
   endgenerate

endmodule

// File: rtl/csdma_ctrl_sva.sv
module csdma_ctrl_sva #(
   parameter int AW        = 32,
   parameter bit IRQ_LEVEL = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dev_ack,
   input logic          hold,
   input logic          hlda,
   input logic [AW-1:0] addr_out,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic          io_rd,
   input logic          io_wr,
   input logic          done,
   input logic          irq
);

   p_bus_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (hold && hlda));

   p_single_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);

   p_strobe_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr) |->
         ((mem_rd && io_wr && !mem_wr && !io_rd) ||
          (mem_wr && io_rd && !mem_rd && !io_wr)));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !hold);

   p_rehold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold) |-> !$past(hlda));

   p_quiet_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!dev_ack && !$rose(hold)));

   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !IRQ_LEVEL) |=> !irq);

   p_addr_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_ack |-> (addr_out == '0));

endmodule

bind csdma_ctrl csdma_ctrl_sva #(.AW(AW), .IRQ_LEVEL(IRQ_LEVEL)) u_sva (.*);

// File: tb/csdma_ctrl_test.sv
module csdma_ctrl_test;

   localparam int AW = 32;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = 2'd0;
   logic [31:0]   cfg_wdata = '0;
   logic          dev_req = 1'b0;
   logic          dev_ack;
   logic          hold;
   logic          hlda;
   logic [AW-1:0] addr_out;
   logic          mem_rd, mem_wr, io_rd, io_wr;
   logic          done, irq;
   logic [SW-1:0] steal_cnt;

   always #2 clk = ~clk;

   csdma_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .dev_req   (dev_req),
      .dev_ack   (dev_ack),
      .hold      (hold),
      .hlda      (hlda),
      .addr_out  (addr_out),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .io_rd     (io_rd),
      .io_wr     (io_wr),
      .done      (done),
      .irq       (irq),
      .steal_cnt (steal_cnt)
   );

   // processor model: grants after one clock, releases after rel_lag extra clocks
   int rel_lag = 0;
   int rel_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hlda    <= 1'b0;
         rel_cnt <= 0;
      end else if (hold) begin
         hlda    <= 1'b1;
         rel_cnt <= 0;
      end else if (hlda) begin
         if (rel_cnt >= rel_lag) hlda <= 1'b0;
         else                    rel_cnt <= rel_cnt + 1;
      end
   end

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          dir;
   } item_t;

   item_t expq[$];
   item_t got_item;
   int    n_cmp = 0;
   int    n_bad = 0;
   int    irq_cnt = 0;
   logic  ack_prev = 1'b0;
   logic  hold_prev = 1'b0;
   logic  hlda_prev = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard pops one item per transfer slot
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) irq_cnt++;
         if (hold && !hold_prev)
            chk("R6 hold raised while hlda still high", 64'(hlda_prev), 64'd0);
         if (dev_ack) begin
            if (ack_prev) chk("R4 slot longer than one clock", 64'd1, 64'd0);
            if (expq.size() == 0) begin
               chk("R4 unexpected transfer slot", 64'd1, 64'd0);
            end else begin
               got_item = expq.pop_front();
               chk("R7 transfer address", 64'(addr_out), 64'(got_item.addr));
               chk("R5 strobe pair", 64'({mem_rd, mem_wr, io_rd, io_wr}),
                   got_item.dir ? 64'b0110 : 64'b1001);
               chk("R3 bus granted in slot", 64'({hold, hlda}), 64'b11);
            end
         end else if (addr_out != '0) begin
            chk("R11 address parked at zero", 64'(addr_out), 64'd0);
         end
         ack_prev  = dev_ack;
         hold_prev = hold;
         hlda_prev = hlda;
      end
   end

   task automatic cfg_write(logic [1:0] sel, logic [31:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // one word with a well-behaved device: request, wait for ack, release
   task automatic one_word();
      int lat;
      @(negedge clk);
      dev_req = 1'b1;
      @(negedge clk);
      chk("R3 hold one clock after request", 64'(hold), 64'd1);
      chk("R3 no ack before grant", 64'(dev_ack), 64'd0);
      lat = 1;
      while (!dev_ack) begin
         @(negedge clk);
         lat++;
      end
      chk("R4 request-to-slot latency", 64'(lat), 64'd3);
      dev_req = 1'b0;
      @(negedge clk);
      chk("R6 hold dropped after slot", 64'(hold), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   // device keeps requesting until n slots seen
   task automatic stream_words(int n);
      int got = 0;
      @(negedge clk);
      dev_req = 1'b1;
      while (got < n) begin
         @(negedge clk);
         if (dev_ack) got++;
      end
      dev_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_job(logic [31:0] base, int count, bit dir, bit poke, bit stream);
      int irq0;
      cfg_write(2'd0, base);
      cfg_write(2'd1, 32'(count));
      for (int i = 0; i < count; i++) begin
         item_t it;
         it.addr = base + 32'(4 * i);
         it.dir  = dir;
         expq.push_back(it);
      end
      irq0 = irq_cnt;
      cfg_write(2'd2, {30'd0, 1'b1, dir});
      chk("R2 arm clears done", 64'(done), 64'd0);
      chk("R2 arm clears steal count", 64'(steal_cnt), 64'd0);
      if (stream) begin
         stream_words(count);
      end else begin
         for (int i = 0; i < count; i++) begin
            one_word();
            if (poke && i == 0) begin
               cfg_write(2'd0, 32'hDEAD_0000);  // R2: ignored while armed
               cfg_write(2'd1, 32'd1);
            end
         end
      end
      chk("R8 done after last word", 64'(done), 64'd1);
      chk("R8 one irq pulse per job", 64'(irq_cnt - irq0), 64'd1);
      chk("R9 stolen slots equal count", 64'(steal_cnt), 64'(count));
      chk("R7 scoreboard drained", 64'(expq.size()), 64'd0);
      dev_req = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R8 request ignored when done", 64'(hold), 64'd0);
      end
      dev_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int irq0;
      repeat (3) @(negedge clk);
      chk("R1 hold after reset", 64'(hold), 64'd0);
      chk("R1 ack after reset", 64'(dev_ack), 64'd0);
      chk("R1 strobes after reset", 64'({mem_rd, mem_wr, io_rd, io_wr}), 64'd0);
      chk("R1 done/irq after reset", 64'({done, irq}), 64'd0);
      chk("R1 steal count after reset", 64'(steal_cnt), 64'd0);
      chk("R1 address after reset", 64'(addr_out), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      dev_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 no hold when unarmed", 64'(hold), 64'd0);
      dev_req = 1'b0;

      run_job(32'h0000_1000, 4, 1'b0, 1'b1, 1'b0);
      run_job(32'h0002_00F0, 3, 1'b1, 1'b0, 1'b0);
      rel_lag = 4;
      run_job(32'hFFFF_FFF8, 3, 1'b1, 1'b0, 1'b1);
      rel_lag = 0;
      run_job(32'h0000_0400, 2, 1'b0, 1'b0, 1'b1);

      // R10: arming with zero count completes at once
      cfg_write(2'd1, 32'd0);
      irq0 = irq_cnt;
      cfg_write(2'd2, 32'h0000_0002);
      chk("R10 done on zero-count arm", 64'(done), 64'd1);
      chk("R10 steal count zero", 64'(steal_cnt), 64'd0);
      dev_req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R10 no bus request", 64'(hold), 64'd0);
      end
      dev_req = 1'b0;
      chk("R10 single irq pulse", 64'(irq_cnt - irq0), 64'd1);

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule